// File: doc/BRIEF.md
# Fail-First Element Loop Sequencer

This block walks an element index from zero up to a vector length supplied at start. For each index it raises a request to an external element unit and waits for the response. The response carries a 4-bit condition result for that element. When recording is on, that result is written to its own condition-field slot: element k goes to field k. When the loop finishes, the block presents the final vector length and pulses done.

In fail-first mode, each element's condition result also goes through a selectable test. The test picks one of the four condition bits and can invert it. The first element whose test is true ends the loop at once, and the final vector length becomes that element's index. No later element is requested. A vector length of zero finishes without issuing any element.

Top module: `elseq_top`

## Requirements
- R1: While reset is held and after it is released, `done`, `busy`, `req_valid` and `cf_we` are low.
- R2: Requests carry indices 0, 1, ..., VL-1 strictly in order. The index advances by one only in the cycle after a response is accepted.
- R3: With `ff_en` set, if the test on element i is true, `vl_out` equals i when `done` rises, and no request for index i+1 or later is issued.
- R4: With `rec_en` set, `cf_we` is high in the response cycle, with `cf_addr` equal to the element index and `cf_data` equal to `rsp_cond`. With `rec_en` clear, `cf_we` stays low.
- R5: Condition bits are LT at bit 3, GT at bit 2, EQ at bit 1 and SO at bit 0. `tst_sel` values 0, 1, 2 and 3 select LT, GT, EQ and SO. The test result is the selected bit XOR `tst_inv`.
- R6: If no element fails, or `ff_en` is clear, `vl_out` equals the VL given at start, up to MAX_VL.
- R7: A start with VL of zero raises `done` in the cycle after the start, with `vl_out` zero, and issues no request.
- R8: Only one request is outstanding at a time. While a request waits for its response, `req_valid` stays high and `req_idx` stays unchanged.
- R9: `start` and all configuration inputs are ignored while `busy` is high. Mode, test and VL are captured only at the accepted start.
- R10: `done` is a one-cycle pulse, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a loop (accepted when idle) |
| vl_in | input | VLW | Initial vector length, clamped to MAX_VL |
| ff_en | input | 1 | Enable data-dependent fail-first |
| rec_en | input | 1 | Enable condition-field writes |
| tst_sel | input | 2 | Condition bit tested: 0 LT, 1 GT, 2 EQ, 3 SO |
| tst_inv | input | 1 | Invert the tested bit |
| req_valid | output | 1 | Element request outstanding |
| req_idx | output | IDXW | Index of the requested element |
| rsp_valid | input | 1 | Element response for the outstanding request |
| rsp_cond | input | 4 | Element condition result {LT,GT,EQ,SO} |
| cf_we | output | 1 | Condition-field write strobe |
| cf_addr | output | IDXW | Condition field written |
| cf_data | output | 4 | Condition value written |
| vl_out | output | VLW | Final vector length, valid with done |
| done | output | 1 | Loop finished (one-cycle pulse) |
| busy | output | 1 | Loop in progress |

## Verification
The condition-field write is combinational on the response, so the bench checks it 1 ns after it drives `rsp_valid`, in the same cycle. The next request index, or `done` together with the truncated `vl_out`, appears one edge after the response. The bench checks those at the following falling edge. A zero-length start is checked one edge after the start pulse, and the end of `done` and `busy` one edge later still. The sweep covers lengths 0 to 5, every selector and invert setting, and fail-first on and off, with varying response latency. A single full 128-element run checks the largest field address and an untruncated length.

// File: rtl/elseq_pkg.sv
package elseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;

  // bit positions inside a 4-bit condition field
  localparam int CB_LT = 3;
  localparam int CB_GT = 2;
  localparam int CB_EQ = 1;
  localparam int CB_SO = 0;
endpackage

// File: rtl/elseq_test.sv
module elseq_test (
  input  logic [3:0] cond,
  input  logic [1:0] sel,
  input  logic       inv,
  output logic       fail
);
  import elseq_pkg::*;

  logic bit_pick;

  always_comb begin
    unique case (sel)
      2'd0:    bit_pick = cond[CB_LT];
      2'd1:    bit_pick = cond[CB_GT];
      2'd2:    bit_pick = cond[CB_EQ];
      default: bit_pick = cond[CB_SO];
    endcase
    fail = bit_pick ^ inv;
  end
endmodule

// File: rtl/elseq_ctrl.sv
module elseq_ctrl #(
  parameter int MAX_VL = 128,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl_in,
  input  logic            ff_en,
  input  logic            rec_en,
  input  logic [1:0]      tst_sel,
  input  logic            tst_inv,
  input  logic            rsp_valid,
  input  logic            fail,
  output logic [1:0]      cfg_sel,
  output logic            cfg_inv,
  output logic            req_valid,
  output logic [IDXW-1:0] req_idx,
  output logic            cf_we,
  output logic [IDXW-1:0] cf_addr,
  output logic [VLW-1:0]  vl_out,
  output logic            done,
  output logic            busy
);
  import elseq_pkg::*;

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

  seq_st_e         st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [VLW-1:0]  vl_q, vl_d;
  logic            ff_q, rec_q, inv_q;
  logic [1:0]      sel_q;
  logic            cfg_ld, accept, last_el;
  logic [VLW-1:0]  vl_clamped;

  assign vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;
  assign cfg_ld     = (st_q == ST_IDLE) && start;
  assign accept     = (st_q == ST_RUN) && rsp_valid;
  assign last_el    = (VLW'(idx_q) + VLW'(1)) == vl_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    vl_d  = vl_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          idx_d = '0;
          vl_d  = vl_clamped;
          st_d  = (vl_clamped == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (rsp_valid) begin
          if (ff_q && fail) begin
            vl_d = VLW'(idx_q);
            st_d = ST_FIN;
          end else if (last_el) begin
            st_d = ST_FIN;
          end else begin
            idx_d = idx_q + IDXW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      vl_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      vl_q  <= vl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q  <= 1'b0;
      rec_q <= 1'b0;
      sel_q <= 2'd0;
      inv_q <= 1'b0;
    end else if (cfg_ld) begin
      ff_q  <= ff_en;
      rec_q <= rec_en;
      sel_q <= tst_sel;
      inv_q <= tst_inv;
    end
  end

  assign cfg_sel   = sel_q;
  assign cfg_inv   = inv_q;
  assign req_valid = (st_q == ST_RUN);
  assign req_idx   = idx_q;
  assign cf_we     = accept && rec_q;
  assign cf_addr   = idx_q;
  assign vl_out    = vl_q;
  assign done      = (st_q == ST_FIN);
  assign busy      = (st_q != ST_IDLE);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_idx)));

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid) |=> (done || (req_valid && req_idx == $past(req_idx) + IDXW'(1))));

  p_zero_vl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && vl_in == '0) |=> (done && !req_valid && vl_out == '0));

  p_trunc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid && ff_q && fail) |=> (done && vl_out == VLW'($past(req_idx))));

  p_rsp_only_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_valid);

  p_no_wr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !cf_we);
endmodule

// File: rtl/elseq_top.sv
module elseq_top #(
  parameter int MAX_VL = 128,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl_in,
  input  logic            ff_en,
  input  logic            rec_en,
  input  logic [1:0]      tst_sel,
  input  logic            tst_inv,
  output logic            req_valid,
  output logic [IDXW-1:0] req_idx,
  input  logic            rsp_valid,
  input  logic [3:0]      rsp_cond,
  output logic            cf_we,
  output logic [IDXW-1:0] cf_addr,
  output logic [3:0]      cf_data,
  output logic [VLW-1:0]  vl_out,
  output logic            done,
  output logic            busy
);
  logic [1:0] cfg_sel;
  logic       cfg_inv;
  logic       fail;

  elseq_test u_test (
    .cond (rsp_cond),
    .sel  (cfg_sel),
    .inv  (cfg_inv),
    .fail (fail)
  );

  elseq_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl_in     (vl_in),
    .ff_en     (ff_en),
    .rec_en    (rec_en),
    .tst_sel   (tst_sel),
    .tst_inv   (tst_inv),
    .rsp_valid (rsp_valid),
    .fail      (fail),
    .cfg_sel   (cfg_sel),
    .cfg_inv   (cfg_inv),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .cf_we     (cf_we),
    .cf_addr   (cf_addr),
    .vl_out    (vl_out),
    .done      (done),
    .busy      (busy)
  );

  assign cf_data = rsp_cond;

  p_cf_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cf_we |-> (rsp_valid && cf_addr == req_idx));
endmodule

// File: tb/test_elseq_top.sv
module test_elseq_top;
  localparam int MAX_VL = 128;
  localparam int VLW  = $clog2(MAX_VL + 1);
  localparam int IDXW = $clog2(MAX_VL);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [VLW-1:0]  vl_in;
  logic            ff_en, rec_en, tst_inv;
  logic [1:0]      tst_sel;
  logic            req_valid;
  logic [IDXW-1:0] req_idx;
  logic            rsp_valid;
  logic [3:0]      rsp_cond;
  logic            cf_we;
  logic [IDXW-1:0] cf_addr;
  logic [3:0]      cf_data;
  logic [VLW-1:0]  vl_out;
  logic            done, busy;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  elseq_top #(.MAX_VL(MAX_VL)) i_elseq_top (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .ff_en(ff_en), .rec_en(rec_en), .tst_sel(tst_sel), .tst_inv(tst_inv),
    .req_valid(req_valid), .req_idx(req_idx), .rsp_valid(rsp_valid),
    .rsp_cond(rsp_cond), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
    .vl_out(vl_out), .done(done), .busy(busy)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(int i, int seed);
    return 4'((i * 5 + seed * 3 + 1) ^ (i >> 1));
  endfunction

  task automatic run_case(int vl, bit ff, bit rec, int sel, bit inv, int seed);
    int  exp_vl = vl;
    bit  stop   = 0;
    logic [3:0] c;
    bit  fb;
    @(negedge clk);
    start = 1; vl_in = VLW'(vl); ff_en = ff; rec_en = rec;
    tst_sel = 2'(sel); tst_inv = inv;
    @(negedge clk);
    start = 0; vl_in = 8'd99; ff_en = ~ff; rec_en = ~rec;
    tst_sel = 2'(sel + 1); tst_inv = ~inv;
    if (vl == 0) begin
      chk(done == 1'b1, "R7", done, 1);
      chk(req_valid == 1'b0, "R7", req_valid, 0);
    end
    for (int i = 0; i < vl && !stop; i++) begin
      int d = (i == 0) ? 1 + (seed % 2) : (i + seed) % 3;
      chk(req_valid && req_idx == IDXW'(i), "R2", req_idx, i);
      for (int k = 0; k < d; k++) begin
        if (i == 0 && k == 0) begin start = 1; vl_in = 8'd3; end
        @(negedge clk);
        start = 0;
        chk(req_valid && req_idx == IDXW'(i), "R8 R9", req_idx, i);
      end
      c = pat(i, seed);
      rsp_valid = 1; rsp_cond = c;
      #1;
      chk(cf_we == rec, "R4", cf_we, rec);
      if (rec) begin
        chk(cf_addr == IDXW'(i), "R4", cf_addr, i);
        chk(cf_data == c, "R4", cf_data, c);
      end
      fb = c[3 - sel] ^ inv;
      if (ff && fb) begin exp_vl = i; stop = 1; end
      @(negedge clk);
      rsp_valid = 0;
    end
    chk(done == 1'b1, "R3 R6", done, 1);
    chk(req_valid == 1'b0, "R3", req_valid, 0);
    chk(vl_out == VLW'(exp_vl), ff ? "R3 R5" : "R6", vl_out, exp_vl);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", {done, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; vl_in = '0; ff_en = 0; rec_en = 0;
    tst_sel = 0; tst_inv = 0; rsp_valid = 0; rsp_cond = '0;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !req_valid && !cf_we, "R1", {done, busy, req_valid, cf_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !busy && !req_valid && !cf_we, "R1", {done, busy, req_valid, cf_we}, 0);
    for (int vl = 0; vl <= 5; vl++)
      for (int sel = 0; sel < 4; sel++)
        for (int inv = 0; inv < 2; inv++)
          for (int ff = 0; ff < 2; ff++)
            run_case(vl, bit'(ff), bit'((vl + sel + inv) % 2), sel, bit'(inv), vl * 7 + sel * 2 + inv);
    run_case(MAX_VL, 1'b0, 1'b1, 0, 1'b0, 4);
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule